// File: doc/BRIEF.md
# Compressor-tree 8x8 unsigned multiplier

This block multiplies two 8-bit unsigned operands into a 16-bit product. Sixty-four AND terms form the partial-product matrix. Two reduction stages built from half adders, full adders and 4-2 compressors cut that matrix down. The first stage leaves at most four bits in any column, and the second leaves two. An exact carry-propagate adder then sums the two remaining rows. The product is ready in the same cycle as the operands, or one clock later when the output register is enabled.

The `APPROX` parameter picks how the compressors in columns 0 to 7 are built. When it is clear, every compressor is exact and the product is always correct. When it is set, those low compressors ignore their carry input and drive their carry output low. They form carry as `(x0&x1)|(x2&x3)` and sum as `(x0^x1)|(x2^x3)`. Every cell in columns 8 and above stays exact. This trades some accuracy in the low bits for fewer gates, for uses such as image filtering.

Top module: `dadda_mul8`

## Requirements
- R1: With `APPROX=0`, `product_o` equals `a_i*b_i` for all 65536 operand pairs.
- R2: Every exact 4-2 compressor satisfies sum + 2*(carry + cout) = x0 + x1 + x2 + x3 + cin for all its input values.
- R3: With `OUT_REG=1`, `product_o` shows the product of the operands present at the previous rising clock edge. It holds that value until the next rising edge, whatever the operands do in between.
- R4: With `OUT_REG=1`, `product_o` is 0 while `rst_ni` is low, even with nonzero operands.
- R5: With `APPROX=1`, `product_o` is never larger than the exact product `a_i*b_i`.
- R6: With `APPROX=1`, `product_o` is 0 whenever either operand is 0.
- R7: With `APPROX=1`, the mean of |exact - approx| / exact over all operand pairs with a nonzero exact product is greater than 0 and at most 0.3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the output register |
| a_i | input | 8 | Unsigned multiplicand |
| b_i | input | 8 | Unsigned multiplier |
| product_o | output | 16 | Unsigned product |

## Verification
The exact variant is driven through the whole operand space in counting order. Each step usually changes only the low operand, so a slip in one partial-product column or in one compressor carry path shows up as a value off by a power of two. Operand pairs that contain a zero check that no cell makes a bit out of nothing. Pairs near 255x255 fill every column and drive every compressor carry high. The approximate variant sees the same sequence. It is judged by the statistics of its error and by its one-sided bound, not by exact values. These checks tell a correct simplification in the low columns apart from one that leaks into the high columns or overestimates.

// File: rtl/dadda_pkg.sv
`timescale 1ns/1ps
package dadda_pkg;
  localparam int unsigned OP_W        = 8;
  localparam int unsigned PROD_W      = 2 * OP_W;
  localparam int unsigned MID_ROWS    = 4;
  localparam int unsigned APPROX_COLS = OP_W;

  typedef logic [OP_W-1:0]                  op_t;
  typedef logic [PROD_W-1:0]                prod_t;
  typedef logic [OP_W-1:0][OP_W-1:0]        pp_t;
  typedef logic [MID_ROWS-1:0][PROD_W-1:0]  rows4_t;
  typedef logic [1:0][PROD_W-1:0]           rows2_t;
endpackage

// File: rtl/dadda_cells.sv
`timescale 1ns/1ps
module dadda_ha (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i;
  assign c_o = x_i & y_i;
endmodule

module dadda_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ z_i;
  assign c_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
endmodule

module dadda_cmp42 #(
  parameter bit APPROX = 1'b0
) (
  input  logic [3:0] x_i,
  input  logic       cin_i,
  output logic       sum_o,
  output logic       carry_o,
  output logic       cout_o
);
  if (APPROX) begin : g_apx
    logic unused_cin;
    assign unused_cin = cin_i;
    assign carry_o    = (x_i[0] & x_i[1]) | (x_i[2] & x_i[3]);
    assign sum_o      = (x_i[0] ^ x_i[1]) | (x_i[2] ^ x_i[3]);
    assign cout_o     = 1'b0;
  end else begin : g_exact
    logic s1;
    assign s1      = ^x_i[2:0];
    assign cout_o  = (x_i[0] & x_i[1]) | (x_i[0] & x_i[2]) | (x_i[1] & x_i[2]);
    assign sum_o   = s1 ^ x_i[3] ^ cin_i;
    assign carry_o = (s1 & x_i[3]) | (s1 & cin_i) | (x_i[3] & cin_i);

    // output weight must match input population
    always_comb begin
      if (!$isunknown({x_i, cin_i})) begin
        p_weight_r2: assert (({2'b00, sum_o} + {1'b0, carry_o, 1'b0} + {1'b0, cout_o, 1'b0}) ==
                             ({2'b00, x_i[0]} + {2'b00, x_i[1]} + {2'b00, x_i[2]} +
                              {2'b00, x_i[3]} + {2'b00, cin_i}))
          else $error("compressor weight mismatch");
      end
    end
  end
endmodule

// File: rtl/dadda_pp_gen.sv
`timescale 1ns/1ps
module dadda_pp_gen import dadda_pkg::*; (
  input  op_t a_i,
  input  op_t b_i,
  output pp_t pp_o
);
  // pp_o[i][j] = a[j] & b[i], weight 2^(i+j)
  for (genvar i = 0; i < OP_W; i++) begin : g_row
    assign pp_o[i] = a_i & {OP_W{b_i[i]}};
  end
endmodule

// File: rtl/dadda_stage1.sv
`timescale 1ns/1ps
module dadda_stage1 import dadda_pkg::*; #(
  parameter bit APPROX = 1'b0
) (
  input  pp_t    pp_i,
  output rows4_t rows_o
);
  logic h4s, h4c, h6s, h6c, h8s, h8c, h12s, h12c;
  logic f8s, f8c, f9s, f9c;
  logic c5s, c5c, c5o, c6s, c6c, c6o;
  logic c7as, c7ac, c7ao, c7bs, c7bc, c7bo;
  logic c8s, c8c, c8o, c9s, c9c, c9o;
  logic c10s, c10c, c10o, c11s, c11c, c11o;

  // columns 4..7: low side, approximate when selected
  dadda_ha u_h4 (.x_i(pp_i[0][4]), .y_i(pp_i[1][3]), .s_o(h4s), .c_o(h4c));

  dadda_cmp42 #(.APPROX(APPROX)) u_c5 (
    .x_i({pp_i[3][2], pp_i[2][3], pp_i[1][4], pp_i[0][5]}), .cin_i(1'b0),
    .sum_o(c5s), .carry_o(c5c), .cout_o(c5o));

  dadda_cmp42 #(.APPROX(APPROX)) u_c6 (
    .x_i({pp_i[3][3], pp_i[2][4], pp_i[1][5], pp_i[0][6]}), .cin_i(c5o),
    .sum_o(c6s), .carry_o(c6c), .cout_o(c6o));
  dadda_ha u_h6 (.x_i(pp_i[4][2]), .y_i(pp_i[5][1]), .s_o(h6s), .c_o(h6c));

  dadda_cmp42 #(.APPROX(APPROX)) u_c7a (
    .x_i({pp_i[3][4], pp_i[2][5], pp_i[1][6], pp_i[0][7]}), .cin_i(c6o),
    .sum_o(c7as), .carry_o(c7ac), .cout_o(c7ao));
  dadda_cmp42 #(.APPROX(APPROX)) u_c7b (
    .x_i({pp_i[7][0], pp_i[6][1], pp_i[5][2], pp_i[4][3]}), .cin_i(1'b0),
    .sum_o(c7bs), .carry_o(c7bc), .cout_o(c7bo));

  // columns 8..13: always exact
  dadda_cmp42 #(.APPROX(1'b0)) u_c8 (
    .x_i({pp_i[4][4], pp_i[3][5], pp_i[2][6], pp_i[1][7]}), .cin_i(c7ao),
    .sum_o(c8s), .carry_o(c8c), .cout_o(c8o));
  dadda_fa u_f8 (.x_i(pp_i[5][3]), .y_i(pp_i[6][2]), .z_i(pp_i[7][1]), .s_o(f8s), .c_o(f8c));
  dadda_ha u_h8 (.x_i(c7ac), .y_i(c7bc), .s_o(h8s), .c_o(h8c));

  dadda_cmp42 #(.APPROX(1'b0)) u_c9 (
    .x_i({pp_i[5][4], pp_i[4][5], pp_i[3][6], pp_i[2][7]}), .cin_i(c8o),
    .sum_o(c9s), .carry_o(c9c), .cout_o(c9o));
  dadda_fa u_f9 (.x_i(pp_i[6][3]), .y_i(pp_i[7][2]), .z_i(c8c), .s_o(f9s), .c_o(f9c));

  dadda_cmp42 #(.APPROX(1'b0)) u_c10 (
    .x_i({pp_i[6][4], pp_i[5][5], pp_i[4][6], pp_i[3][7]}), .cin_i(c9o),
    .sum_o(c10s), .carry_o(c10c), .cout_o(c10o));

  dadda_cmp42 #(.APPROX(1'b0)) u_c11 (
    .x_i({pp_i[7][4], pp_i[6][5], pp_i[5][6], pp_i[4][7]}), .cin_i(c10o),
    .sum_o(c11s), .carry_o(c11c), .cout_o(c11o));

  dadda_ha u_h12 (.x_i(pp_i[5][7]), .y_i(pp_i[6][6]), .s_o(h12s), .c_o(h12c));

  // place survivors, at most four per column
  always_comb begin
    rows_o = '0;
    rows_o[0][0]  = pp_i[0][0];
    rows_o[0][1]  = pp_i[0][1]; rows_o[1][1]  = pp_i[1][0];
    rows_o[0][2]  = pp_i[0][2]; rows_o[1][2]  = pp_i[1][1]; rows_o[2][2]  = pp_i[2][0];
    rows_o[0][3]  = pp_i[0][3]; rows_o[1][3]  = pp_i[1][2]; rows_o[2][3]  = pp_i[2][1];
    rows_o[3][3]  = pp_i[3][0];
    rows_o[0][4]  = h4s;        rows_o[1][4]  = pp_i[2][2]; rows_o[2][4]  = pp_i[3][1];
    rows_o[3][4]  = pp_i[4][0];
    rows_o[0][5]  = c5s;        rows_o[1][5]  = pp_i[4][1]; rows_o[2][5]  = pp_i[5][0];
    rows_o[3][5]  = h4c;
    rows_o[0][6]  = c6s;        rows_o[1][6]  = h6s;        rows_o[2][6]  = pp_i[6][0];
    rows_o[3][6]  = c5c;
    rows_o[0][7]  = c7as;       rows_o[1][7]  = c7bs;       rows_o[2][7]  = c6c;
    rows_o[3][7]  = h6c;
    rows_o[0][8]  = c8s;        rows_o[1][8]  = f8s;        rows_o[2][8]  = h8s;
    rows_o[3][8]  = c7bo;
    rows_o[0][9]  = c9s;        rows_o[1][9]  = f9s;        rows_o[2][9]  = f8c;
    rows_o[3][9]  = h8c;
    rows_o[0][10] = c10s;       rows_o[1][10] = pp_i[7][3]; rows_o[2][10] = c9c;
    rows_o[3][10] = f9c;
    rows_o[0][11] = c11s;       rows_o[1][11] = c10c;
    rows_o[0][12] = h12s;       rows_o[1][12] = pp_i[7][5]; rows_o[2][12] = c11c;
    rows_o[3][12] = c11o;
    rows_o[0][13] = pp_i[6][7]; rows_o[1][13] = pp_i[7][6]; rows_o[2][13] = h12c;
    rows_o[0][14] = pp_i[7][7];
  end
endmodule

// File: rtl/dadda_stage2.sv
`timescale 1ns/1ps
module dadda_stage2 import dadda_pkg::*; #(
  parameter bit APPROX = 1'b0
) (
  input  rows4_t rows_i,
  output rows2_t rows_o
);
  localparam int unsigned FIRST_CMP = 3;
  localparam int unsigned LAST_CMP  = PROD_W - 3;

  logic unused_rows;
  logic ha_s, ha_c, fa_s, fa_c;
  logic [LAST_CMP:FIRST_CMP] cmp_s, cmp_c, cmp_o;

  assign unused_rows = ^rows_i;

  dadda_ha u_h2 (.x_i(rows_i[0][2]), .y_i(rows_i[1][2]), .s_o(ha_s), .c_o(ha_c));

  // one compressor per column, carry-out chained into the next column
  for (genvar c = FIRST_CMP; c <= LAST_CMP; c++) begin : g_col
    logic cin_w;
    if (c == FIRST_CMP) begin : g_head
      assign cin_w = ha_c;
    end else begin : g_link
      assign cin_w = cmp_o[c-1];
    end
    dadda_cmp42 #(.APPROX(APPROX && (c < APPROX_COLS))) u_cmp (
      .x_i({rows_i[3][c], rows_i[2][c], rows_i[1][c], rows_i[0][c]}),
      .cin_i(cin_w), .sum_o(cmp_s[c]), .carry_o(cmp_c[c]), .cout_o(cmp_o[c]));
  end

  dadda_fa u_f14 (.x_i(rows_i[0][PROD_W-2]), .y_i(cmp_c[LAST_CMP]), .z_i(cmp_o[LAST_CMP]),
                  .s_o(fa_s), .c_o(fa_c));

  always_comb begin
    rows_o = '0;
    rows_o[0][0] = rows_i[0][0];
    rows_o[0][1] = rows_i[0][1];
    rows_o[1][1] = rows_i[1][1];
    rows_o[0][2] = ha_s;
    rows_o[1][2] = rows_i[2][2];
    rows_o[0][LAST_CMP:FIRST_CMP]     = cmp_s;
    rows_o[1][LAST_CMP:FIRST_CMP+1]   = cmp_c[LAST_CMP-1:FIRST_CMP];
    rows_o[0][PROD_W-2] = fa_s;
    rows_o[0][PROD_W-1] = fa_c;
  end
endmodule

// File: rtl/dadda_cpa.sv
`timescale 1ns/1ps
module dadda_cpa #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  assign s_o = x_i + y_i;
endmodule

// File: rtl/dadda_mul8.sv
`timescale 1ns/1ps
module dadda_mul8 import dadda_pkg::*; #(
  parameter bit APPROX  = 1'b0,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [PROD_W-1:0] product_o
);
  pp_t    pp;
  rows4_t mid_rows;
  rows2_t fin_rows;
  prod_t  prod_comb;
  prod_t  exact_ref;

  dadda_pp_gen u_pp (.a_i(a_i), .b_i(b_i), .pp_o(pp));

  dadda_stage1 #(.APPROX(APPROX)) u_s1 (.pp_i(pp), .rows_o(mid_rows));

  dadda_stage2 #(.APPROX(APPROX)) u_s2 (.rows_i(mid_rows), .rows_o(fin_rows));

  dadda_cpa #(.W(PROD_W)) u_cpa (.x_i(fin_rows[0]), .y_i(fin_rows[1]), .s_o(prod_comb));

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) product_o <= '0;
      else         product_o <= prod_comb;
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign product_o  = prod_comb;
  end

  assign exact_ref = {{OP_W{1'b0}}, a_i} * {{OP_W{1'b0}}, b_i};

  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_i == '0) || (b_i == '0)) |-> (prod_comb == '0));

  if (APPROX) begin : g_chk_apx
    p_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prod_comb <= exact_ref);
  end else begin : g_chk_exact
    p_exact_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prod_comb == exact_ref);
    if (OUT_REG) begin : g_chk_lat
      p_latency_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (product_o == $past(exact_ref)));
    end
  end
endmodule

// File: tb/test_dadda_mul8.sv
`timescale 1ns/1ps
module test_dadda_mul8;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  a_i, b_i;
  logic [15:0] prod_x, prod_a;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk_i = ~clk_i;

  dadda_mul8 #(.APPROX(1'b0), .OUT_REG(1'b1)) i_dadda_mul8 (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .product_o(prod_x));

  dadda_mul8 #(.APPROX(1'b1), .OUT_REG(1'b0)) i_dadda_mul8_apx (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .product_o(prod_a));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%0d b=%0d actual %0d expected %0d", req, a_i, b_i, act, exp);
    end
  endtask

  initial begin
    logic [15:0] q[$];
    logic [15:0] prev_exp;
    logic [15:0] want;
    real         red_sum;
    int          red_cnt;
    real         mred;
    red_sum = 0.0;
    red_cnt = 0;
    a_i = '0;
    b_i = '0;
    rst_ni = 1'b1;
    #2 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R4 reset", prod_x, 16'd0);
    a_i = 8'd200; b_i = 8'd201;
    @(negedge clk_i);
    check("R4 reset with operands", prod_x, 16'd0);
    a_i = 8'd0;   b_i = 8'd77;
    #1 check("R6 zero a", prod_a, 16'd0);
    @(negedge clk_i);
    rst_ni   = 1'b1;
    prev_exp = 16'd0;
    for (int i = 0; i < 65536; i++) begin
      a_i  = i[15:8];
      b_i  = i[7:0];
      want = 16'(i[15:8]) * 16'(i[7:0]);
      q.push_back(want);
      #1;
      // registered output still shows the previous product
      check("R3 hold", prod_x, prev_exp);
      n_chk++;
      if (prod_a > want) begin
        n_bad++;
        $display("FAIL R5: a=%0d b=%0d actual %0d expected <= %0d", a_i, b_i, prod_a, want);
      end
      if (a_i == 8'd0 || b_i == 8'd0) check("R6 zero operand", prod_a, 16'd0);
      if (want != 16'd0) begin
        red_sum += (want >= prod_a) ? real'(want - prod_a) / real'(want)
                                    : real'(prod_a - want) / real'(want);
        red_cnt++;
      end
      @(negedge clk_i);
      prev_exp = q.pop_front();
      check("R1 R2 R3 product", prod_x, prev_exp);
    end
    mred = red_sum / real'(red_cnt);
    n_chk++;
    if (!(mred > 0.0 && mred <= 0.3)) begin
      n_bad++;
      $display("FAIL R7: actual mred %f expected in (0, 0.3]", mred);
    end else begin
      $display("approximate mode mred %f", mred);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule